// File: doc/BRIEF.md
# Register Pending-Write Hazard Scoreboard

This block sits at the issue point of an in-order pipeline. It keeps a record of which architectural registers are waiting for a result from an instruction still in flight, and of how many in-flight instructions still have to read each register. Every cycle it compares the instruction waiting to issue against that record. Each candidate has up to two source registers and one destination register, and every field carries its own valid bit.

The comparison is a set overlap. The candidate's read set is tested against the pending-write record, which gives a read-after-write conflict. Its write set is tested against the same record, which gives a write-after-write conflict. Its write set is also tested against the registers that still have unread uses, which gives a write-after-read conflict. Any conflict raises `stall`, and the candidate is then not accepted. A candidate is accepted when `issue_req` is high and `stall` is low. On acceptance its destination is reserved and one unread use is recorded for each of its valid sources.

Completion ports remove reservations when results finish. Operand-read ports retire unread uses when operands are fetched. Register 0 is treated as a constant register and never takes part in any of this.

Top module: `hazard_scoreboard`

## Requirements
- R1: After reset no register is reserved and no register has unread uses, so the first issue attempt on any register indices reports no hazard.
- R2: `haz_raw` is high when `issue_req` is high and a valid source index names a register reserved by an accepted, uncompleted instruction.
- R3: `haz_waw` is high when `issue_req` is high and the valid destination index names a reserved register.
- R4: `haz_war` is high when `issue_req` is high and the valid destination index names a register with at least one unread use outstanding.
- R5: Index 0 in any field is never reserved, never counted as a use, and never raises a hazard flag.
- R6: An attempt is accepted only when `stall` is low. A stalled attempt changes neither reservations nor use counts.
- R7: A completion port entry with its valid bit set clears the reservation of its register at the next clock edge. Both completion ports act in the same cycle.
- R8: When a completion and an accepted reservation name the same register in one cycle, that register is reserved after the edge.
- R9: Each valid source of an accepted instruction adds one unread use. Two sources naming the same register add two. Each valid operand-read port entry removes one use.
- R10: With `issue_req` low, all three flags and `stall` are low. Otherwise `stall` is high exactly when at least one flag is high.
- R11: A source or destination field whose valid bit is low takes no part in the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_req | input | 1 | An instruction is trying to issue this cycle |
| src0_vld | input | 1 | First source field is used |
| src0_idx | input | IDX_W | First source register index |
| src1_vld | input | 1 | Second source field is used |
| src1_idx | input | IDX_W | Second source register index |
| dst_vld | input | 1 | Destination field is used |
| dst_idx | input | IDX_W | Destination register index |
| cmp_vld | input | NUM_CMP | Per completion port: a result has finished |
| cmp_idx | input | NUM_CMP*IDX_W | Packed register indices of the finished results, port 0 in the low bits |
| rdone_vld | input | NUM_RDP | Per operand-read port: one pending use was read |
| rdone_idx | input | NUM_RDP*IDX_W | Packed register indices of the operands that were read, port 0 in the low bits |
| stall | output | 1 | Candidate must not issue this cycle |
| haz_raw | output | 1 | Read-after-write conflict |
| haz_waw | output | 1 | Write-after-write conflict |
| haz_war | output | 1 | Write-after-read conflict |

## Verification
The two cases that are hardest to reach from the ports are a release and a fresh reservation landing on the same register in the same cycle, and a register whose use count goes above one. The first needs a register that has no reservation, so that the new writer is not stalled by WAW, while a completion for that same index is presented at the same edge. A following read of that register then shows which event won. The second is set up by an accepted instruction whose two sources name the same register, with the operand-read ports retiring one use at a time. A writer to that register is tried after each step and must keep stalling until the count reaches zero.

// File: rtl/hsb_pkg.sv
// Shared types for the hazard scoreboard.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package hsb_pkg;

    // One bit per hazard class reported at the issue point.
    typedef struct packed {
        logic raw;
        logic waw;
        logic war;
    } hsb_flags_t;

endpackage

// File: rtl/hsb_idx_decode.sv
// Turns a group of (valid, index) fields into a per-register hit count.
// Assumes: index 0 is a constant register, so its count is always zero.
// The count width covers the case where every input names the same register.
module hsb_idx_decode #(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = 5,
    parameter int NUM_IN   = 2,
    localparam int CW      = $clog2(NUM_IN + 1)
) (
    input  logic [NUM_IN-1:0]       vld_i,
    input  logic [NUM_IN*IDX_W-1:0] idx_i,
    output logic [NUM_REGS*CW-1:0]  cnt_o
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        if (r == 0) begin : g_zero
            // Register 0 never matches.
            assign cnt_o[CW-1:0] = '0;
        end else begin : g_live
            logic [CW-1:0] acc;
            // Count the valid inputs whose index equals this register.
            always_comb begin
                acc = '0;
                for (int k = 0; k < NUM_IN; k++) begin
                    if (vld_i[k] && (idx_i[k*IDX_W +: IDX_W] == IDX_W'(r))) begin
                        acc = acc + CW'(1);
                    end
                end
            end
            assign cnt_o[r*CW +: CW] = acc;
        end
    end

endmodule

// File: rtl/hsb_pend_bank.sv
// Holds one pending-write bit per register.
// Assumes: reserve and release masks already exclude register 0.
// A reservation overrides a release on the same register in the same cycle.
module hsb_pend_bank #(
    parameter int NUM_REGS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] reserve_i,
    input  logic [NUM_REGS-1:0] release_i,
    output logic [NUM_REGS-1:0] pend_o
);

    logic [NUM_REGS-1:0] pend_q;

    // Update reservations; reset clears them all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= reserve_i | (pend_q & ~release_i);
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/hsb_use_bank.sv
// Counts outstanding unread source uses per register.
// Assumes: no register ever gets more than 2**CNT_W-1 unread uses, and
// an operand-read event only names a register that has a use outstanding.
module hsb_use_bank #(
    parameter int NUM_REGS = 32,
    parameter int CNT_W    = 3,
    parameter int INC_W    = 2,
    parameter int DEC_W    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      inc_en_i,
    input  logic [NUM_REGS*INC_W-1:0] inc_i,
    input  logic [NUM_REGS*DEC_W-1:0] dec_i,
    output logic [NUM_REGS*CNT_W-1:0] cnt_o,
    output logic [NUM_REGS-1:0]       busy_o
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_cnt
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W-1:0] add_v;
        logic [CNT_W-1:0] sub_v;

        // Pick this register's increment (only on acceptance) and decrement.
        always_comb begin
            add_v = inc_en_i ? CNT_W'(inc_i[r*INC_W +: INC_W]) : '0;
            sub_v = CNT_W'(dec_i[r*DEC_W +: DEC_W]);
        end

        // Apply the net change once per cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + add_v - sub_v;
            end
        end

        assign cnt_o[r*CNT_W +: CNT_W] = cnt_q;
        assign busy_o[r]               = |cnt_q;
    end

endmodule

// File: rtl/hazard_scoreboard.sv
// Issue-point hazard scoreboard. It tests the read and write sets of the
// candidate instruction against the pending-write bits and the unread-use
// counts, and it updates both records from acceptance, completion and
// operand-read events.
// Assumes: in-order issue, one candidate per cycle, register 0 constant.
module hazard_scoreboard
    import hsb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int NUM_CMP  = 2,
    parameter int NUM_RDP  = 2,
    parameter int CNT_W    = 3,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue_req,
    input  logic                     src0_vld,
    input  logic [IDX_W-1:0]         src0_idx,
    input  logic                     src1_vld,
    input  logic [IDX_W-1:0]         src1_idx,
    input  logic                     dst_vld,
    input  logic [IDX_W-1:0]         dst_idx,
    input  logic [NUM_CMP-1:0]       cmp_vld,
    input  logic [NUM_CMP*IDX_W-1:0] cmp_idx,
    input  logic [NUM_RDP-1:0]       rdone_vld,
    input  logic [NUM_RDP*IDX_W-1:0] rdone_idx,
    output logic                     stall,
    output logic                     haz_raw,
    output logic                     haz_waw,
    output logic                     haz_war
);

    localparam int SRC_W = $clog2(3);
    localparam int CMP_W = $clog2(NUM_CMP + 1);
    localparam int RDP_W = $clog2(NUM_RDP + 1);

    logic [NUM_REGS*SRC_W-1:0] rd_cnt;
    logic [NUM_REGS-1:0]       wr_hit;
    logic [NUM_REGS*CMP_W-1:0] cmp_cnt;
    logic [NUM_REGS*RDP_W-1:0] rdone_cnt;
    logic [NUM_REGS-1:0]       rd_hit;
    logic [NUM_REGS-1:0]       rel_hit;
    logic [NUM_REGS-1:0]       pend_q;
    logic [NUM_REGS-1:0]       busy;
    logic [NUM_REGS*CNT_W-1:0] use_cnt_q;
    logic [NUM_REGS-1:0]       reserve;
    hsb_flags_t                flags;
    logic                      accept;

    hsb_idx_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .NUM_IN(2)) u_src_dec (
        .vld_i ({src1_vld, src0_vld}),
        .idx_i ({src1_idx, src0_idx}),
        .cnt_o (rd_cnt)
    );

    hsb_idx_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .NUM_IN(1)) u_dst_dec (
        .vld_i (dst_vld),
        .idx_i (dst_idx),
        .cnt_o (wr_hit)
    );

    hsb_idx_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .NUM_IN(NUM_CMP)) u_cmp_dec (
        .vld_i (cmp_vld),
        .idx_i (cmp_idx),
        .cnt_o (cmp_cnt)
    );

    hsb_idx_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .NUM_IN(NUM_RDP)) u_rdp_dec (
        .vld_i (rdone_vld),
        .idx_i (rdone_idx),
        .cnt_o (rdone_cnt)
    );

    // Reduce per-register counts to hit masks where only presence matters.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_mask
        assign rd_hit[r]  = |rd_cnt[r*SRC_W +: SRC_W];
        assign rel_hit[r] = |cmp_cnt[r*CMP_W +: CMP_W];
    end

    // Hazard classes by set intersection against the current record.
    always_comb begin
        flags.raw = issue_req & (|(rd_hit & pend_q));
        flags.waw = issue_req & (|(wr_hit & pend_q));
        flags.war = issue_req & (|(wr_hit & busy));
    end

    assign haz_raw = flags.raw;
    assign haz_waw = flags.waw;
    assign haz_war = flags.war;
    assign stall   = flags.raw | flags.waw | flags.war;
    assign accept  = issue_req & ~stall;
    assign reserve = wr_hit & {NUM_REGS{accept}};

    hsb_pend_bank #(.NUM_REGS(NUM_REGS)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .reserve_i (reserve),
        .release_i (rel_hit),
        .pend_o    (pend_q)
    );

    hsb_use_bank #(
        .NUM_REGS (NUM_REGS),
        .CNT_W    (CNT_W),
        .INC_W    (SRC_W),
        .DEC_W    (RDP_W)
    ) u_use (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_en_i (accept),
        .inc_i    (rd_cnt),
        .dec_i    (rdone_cnt),
        .cnt_o    (use_cnt_q),
        .busy_o   (busy)
    );

endmodule

// File: rtl/hsb_checker.sv
// Property checker for hazard_scoreboard, attached with bind.
// Assumes it sees the top's ports plus its pending-bit and use-count state.
module hsb_checker #(
    parameter int NUM_REGS = 32,
    parameter int NUM_CMP  = 2,
    parameter int NUM_RDP  = 2,
    parameter int CNT_W    = 3,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     issue_req,
    input logic                     src0_vld,
    input logic [IDX_W-1:0]         src0_idx,
    input logic                     src1_vld,
    input logic [IDX_W-1:0]         src1_idx,
    input logic                     dst_vld,
    input logic [IDX_W-1:0]         dst_idx,
    input logic [NUM_CMP-1:0]       cmp_vld,
    input logic [NUM_CMP*IDX_W-1:0] cmp_idx,
    input logic [NUM_RDP-1:0]       rdone_vld,
    input logic                     stall,
    input logic                     haz_raw,
    input logic                     haz_waw,
    input logic                     haz_war,
    input logic [NUM_REGS-1:0]      pend_q,
    input logic [NUM_REGS*CNT_W-1:0] use_cnt_q
);

    // R10: no attempt, no flags.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_req |-> !(stall || haz_raw || haz_waw || haz_war));

    // R5: an attempt touching only register 0 never stalls.
    p_zero_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_req && (!src0_vld || src0_idx == '0) && (!src1_vld || src1_idx == '0)
         && (!dst_vld || dst_idx == '0)) |-> !stall);

    // R2: a valid source on a reserved register reports RAW.
    p_raw_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_req && src0_vld && src0_idx != '0 && pend_q[src0_idx]) |-> haz_raw);

    // R8: an accepted reservation survives a release in the same cycle.
    p_reserve_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_req && !stall && dst_vld && dst_idx != '0) |=> pend_q[$past(dst_idx)]);

    // R7: completion clears the register when no new writer claims it.
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_vld[0] && cmp_idx[IDX_W-1:0] != '0 &&
         !(issue_req && !stall && dst_vld && dst_idx == cmp_idx[IDX_W-1:0]))
        |=> !pend_q[$past(cmp_idx[IDX_W-1:0])]);

    // R6: a stalled attempt with no other events leaves the record alone.
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_req && stall && cmp_vld == '0 && rdone_vld == '0)
        |=> ($stable(pend_q) && $stable(use_cnt_q)));

endmodule

bind hazard_scoreboard hsb_checker #(
    .NUM_REGS (NUM_REGS),
    .NUM_CMP  (NUM_CMP),
    .NUM_RDP  (NUM_RDP),
    .CNT_W    (CNT_W)
) u_hsb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_req (issue_req),
    .src0_vld  (src0_vld),
    .src0_idx  (src0_idx),
    .src1_vld  (src1_vld),
    .src1_idx  (src1_idx),
    .dst_vld   (dst_vld),
    .dst_idx   (dst_idx),
    .cmp_vld   (cmp_vld),
    .cmp_idx   (cmp_idx),
    .rdone_vld (rdone_vld),
    .stall     (stall),
    .haz_raw   (haz_raw),
    .haz_waw   (haz_waw),
    .haz_war   (haz_war),
    .pend_q    (pend_q),
    .use_cnt_q (use_cnt_q)
);

// File: tb/hazard_scoreboard_tb_top.sv
// Scoreboard bench: the driver applies one cycle of stimulus, computes the
// expected flags from its own model of the requirements and queues them;
// the monitor pops and compares them shortly after the falling edge.
module hazard_scoreboard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NR   = 32;
    localparam int IW   = 5;
    localparam int NC   = 2;
    localparam int NRD  = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            issue_req = 1'b0;
    logic            src0_vld = 1'b0, src1_vld = 1'b0, dst_vld = 1'b0;
    logic [IW-1:0]   src0_idx = '0, src1_idx = '0, dst_idx = '0;
    logic [NC-1:0]   cmp_vld = '0;
    logic [NC*IW-1:0] cmp_idx = '0;
    logic [NRD-1:0]  rdone_vld = '0;
    logic [NRD*IW-1:0] rdone_idx = '0;
    logic            stall, haz_raw, haz_waw, haz_war;

    typedef struct {
        logic  raw, waw, war, stl;
        string req;
    } exp_t;

    exp_t  exp_q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    bit    pend_m[NR];
    int    cnt_m[NR];

    // staged stimulus for the next cycle
    logic          s_iss, s_s0v, s_s1v, s_dv;
    int            s_s0, s_s1, s_d;
    logic [NC-1:0] s_cv;
    int            s_c[NC];
    logic [NRD-1:0] s_rv;
    int            s_r[NRD];

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_scoreboard dut_i (
        .clk(clk), .rst_n(rst_n), .issue_req(issue_req),
        .src0_vld(src0_vld), .src0_idx(src0_idx),
        .src1_vld(src1_vld), .src1_idx(src1_idx),
        .dst_vld(dst_vld), .dst_idx(dst_idx),
        .cmp_vld(cmp_vld), .cmp_idx(cmp_idx),
        .rdone_vld(rdone_vld), .rdone_idx(rdone_idx),
        .stall(stall), .haz_raw(haz_raw), .haz_waw(haz_waw), .haz_war(haz_war)
    );

    task automatic clear_stage();
        s_iss = 0; s_s0v = 0; s_s1v = 0; s_dv = 0;
        s_s0 = 0; s_s1 = 0; s_d = 0; s_cv = '0; s_rv = '0;
        for (int k = 0; k < NC; k++) s_c[k] = 0;
        for (int k = 0; k < NRD; k++) s_r[k] = 0;
    endtask

    task automatic stage_issue(input logic s0v, input int s0, input logic s1v,
                               input int s1, input logic dv, input int d);
        s_iss = 1; s_s0v = s0v; s_s0 = s0; s_s1v = s1v; s_s1 = s1; s_dv = dv; s_d = d;
    endtask

    // Apply staged stimulus for one cycle, queue the expectation, update the model.
    task automatic cycle(input string req, input bit chk);
        exp_t e;
        bit   acc;
        @(negedge clk);
        issue_req = s_iss; src0_vld = s_s0v; src0_idx = IW'(s_s0);
        src1_vld = s_s1v; src1_idx = IW'(s_s1); dst_vld = s_dv; dst_idx = IW'(s_d);
        cmp_vld = s_cv; rdone_vld = s_rv;
        for (int k = 0; k < NC; k++)  cmp_idx[k*IW +: IW]   = IW'(s_c[k]);
        for (int k = 0; k < NRD; k++) rdone_idx[k*IW +: IW] = IW'(s_r[k]);
        e.raw = s_iss && ((s_s0v && s_s0 != 0 && pend_m[s_s0]) ||
                          (s_s1v && s_s1 != 0 && pend_m[s_s1]));
        e.waw = s_iss && s_dv && s_d != 0 && pend_m[s_d];
        e.war = s_iss && s_dv && s_d != 0 && cnt_m[s_d] > 0;
        e.stl = e.raw || e.waw || e.war;
        e.req = req;
        if (chk) exp_q.push_back(e);
        acc = s_iss && !e.stl;
        if (acc && s_s0v && s_s0 != 0) cnt_m[s_s0]++;
        if (acc && s_s1v && s_s1 != 0) cnt_m[s_s1]++;
        for (int k = 0; k < NRD; k++) if (s_rv[k] && s_r[k] != 0) cnt_m[s_r[k]]--;
        for (int k = 0; k < NC; k++)  if (s_cv[k] && s_c[k] != 0) pend_m[s_c[k]] = 0;
        if (acc && s_dv && s_d != 0) pend_m[s_d] = 1;
    endtask

    // Monitor: compare queued expectations with the outputs mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if ({haz_raw, haz_waw, haz_war, stall} !== {e.raw, e.waw, e.war, e.stl}) begin
                    n_errors++;
                    $display("FAIL %s: raw/waw/war/stall got %b%b%b%b expected %b%b%b%b",
                             e.req, haz_raw, haz_waw, haz_war, stall, e.raw, e.waw, e.war, e.stl);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) begin pend_m[i] = 0; cnt_m[i] = 0; end
        clear_stage();
        repeat (3) cycle("reset", 0);
        rst_n = 1'b1;

        // R1: fresh state, nothing conflicts
        stage_issue(1, 5, 1, 7, 1, 9);   cycle("R1 first issue", 1); clear_stage();
        stage_issue(1, 31, 1, 1, 1, 2);  cycle("R1 other regs", 1); clear_stage();

        // R2: read of reserved r9 on either source
        stage_issue(1, 9, 0, 0, 1, 12);  cycle("R2 raw src0", 1); clear_stage();
        stage_issue(1, 3, 1, 9, 0, 0);   cycle("R2 raw src1", 1); clear_stage();
        // R6: the stalled writer of r12 left no reservation
        stage_issue(0, 0, 0, 0, 1, 12);  cycle("R6 stalled issue did not reserve", 1); clear_stage();

        // R3: second writer of r9
        stage_issue(0, 0, 0, 0, 1, 9);   cycle("R3 waw", 1); clear_stage();
        // R4: r5 has one unread use
        stage_issue(0, 0, 0, 0, 1, 5);   cycle("R4 war", 1); clear_stage();

        // R11: invalid fields ignored
        stage_issue(0, 9, 0, 9, 0, 9);   cycle("R11 invalid fields", 1); clear_stage();
        // R10: no request, no flags even on reserved registers
        s_s0v = 1; s_s0 = 9; s_dv = 1; s_d = 2; cycle("R10 idle", 1); clear_stage();

        // R9: read-done retires uses of r5 and r7, then writing r5 is clean
        s_rv = 2'b11; s_r[0] = 5; s_r[1] = 7; cycle("R9 read-done", 0); clear_stage();
        stage_issue(0, 0, 0, 0, 1, 5);   cycle("R9 war cleared", 1); clear_stage();
        // R9: double use of r20
        stage_issue(1, 20, 1, 20, 0, 0); cycle("R9 double use issue", 1); clear_stage();
        s_rv = 2'b01; s_r[0] = 20;       cycle("R9 one read", 0); clear_stage();
        stage_issue(0, 0, 0, 0, 1, 20);  cycle("R9 one use left", 1); clear_stage();
        s_rv = 2'b10; s_r[1] = 20;       cycle("R9 second read", 0); clear_stage();
        stage_issue(0, 0, 0, 0, 1, 20);  cycle("R9 uses gone", 1); clear_stage();

        // R7: both completion ports at once (r9 and r12)
        s_cv = 2'b11; s_c[0] = 9; s_c[1] = 12; cycle("R7 release", 0); clear_stage();
        stage_issue(1, 9, 1, 12, 0, 0);  cycle("R7 released regs readable", 1); clear_stage();
        // R7: port 1 alone releases r5
        s_cv = 2'b10; s_c[1] = 5;        cycle("R7 port1", 0); clear_stage();
        stage_issue(1, 5, 0, 0, 0, 0);   cycle("R7 port1 release", 1); clear_stage();

        // R8: completion and accepted reservation on r14 in one cycle
        stage_issue(0, 0, 0, 0, 1, 14); s_cv = 2'b01; s_c[0] = 14;
        cycle("R8 same-cycle accept", 1); clear_stage();
        stage_issue(1, 14, 0, 0, 0, 0);  cycle("R8 reservation won", 1); clear_stage();

        // R5: register 0 everywhere, twice, plus a completion on 0
        stage_issue(1, 0, 1, 0, 1, 0); s_cv = 2'b01; s_c[0] = 0;
        cycle("R5 zero reg", 1); clear_stage();
        stage_issue(1, 0, 1, 0, 1, 0);   cycle("R5 zero never reserved", 1); clear_stage();

        // R1: reset clears a busy record
        rst_n = 1'b0; cycle("reset again", 0); rst_n = 1'b1;
        for (int i = 0; i < NR; i++) begin pend_m[i] = 0; cnt_m[i] = 0; end
        stage_issue(1, 14, 1, 2, 1, 20); cycle("R1 after second reset", 1); clear_stage();

        repeat (3) cycle("drain", 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule